// File: doc/BRIEF.md
# Wide Register Bus Collector

This block is a host-bus slave sitting in front of a bank of 128-bit control registers and a table of 64-bit buffer entries, reached over a bus whose accesses are only 32 or 64 bits wide. A write to a wide register arrives as several pieces. The lower pieces are parked in a single shared collector. The write of the top piece then lands the whole assembled value in the addressed register in one clock edge, so the rest of the chip never sees a half-updated register. Reads work the other way round. Reading the lowest dword of a wide register copies the full register into a shadow buffer, and the higher dwords are then served from that copy. The host therefore gets a coherent 128-bit value even if the live register changes between its reads.

A few dword-sized registers bypass the collector entirely. These are the event-queue read pointer and the receive and transmit descriptor updates. A lone 32-bit write to one of them takes effect at once, and it leaves any half-collected wide write untouched. The register set repeats per page at a fixed stride. The buffer table lives in page 0 and has its own 32-bit hold register. All register contents are presented as flat output vectors for the logic that consumes them.

Top module: `wreg_collector`

## Requirements
- R1: While reset is asserted and on release, every wide register, bypass register, buffer entry and the read data are zero. The collector and the shadow are also cleared.
- R2: Wide register i of page p sits at byte address p*0x2000 + 16*i. For 32-bit writes, the pieces at offsets 0, 4 and 8 are only collected. The write at offset 12 commits {that data, collected dword 2, dword 1, dword 0} to the register named by the final piece's address. Until then no wide register changes.
- R3: A 64-bit write (wide_i=1) at offset 0 collects the low 64 bits. A 64-bit write at offset 8 commits {data, collected low 64 bits}.
- R4: A commit does not clear the collector. Pieces not rewritten since the last commit keep their earlier values, and these values are used in the next commit.
- R5: A read at offset 0 of a wide register returns its live low dword (or low 64 bits for a 64-bit read) and copies the whole register into the shadow. Reads at offsets 4, 8 and 12 (64-bit: offset 8) return shadow data. The shadow holds its value until the next offset-0 read of any wide register.
- R6: Read data appears on rdata_o in the cycle after re_i is sampled. A 32-bit read is zero-extended to 64 bits. In every cycle after one without a read, rdata_o is zero.
- R7: Each page has three 32-bit bypass registers at offsets 0x100, 0x110 and 0x120. A 32-bit write there updates the register at the next edge, and a 32-bit read returns it.
- R8: A bypass write during a partly collected wide write leaves the collector unchanged, and the pending wide write still commits the correct value.
- R9: Buffer entry e sits at 0x1000 + 8*e, in page 0 only. A 32-bit write at +0 is held. A 32-bit write at +4 commits {data, held}. A 64-bit write at +0 commits directly. 32-bit reads at +0 and +4 return the low and high halves.
- R10: Pages repeat every 0x2000 bytes. A page-1 address reaches only page-1 registers, and the collector is shared across pages.
- R11: Unmapped accesses read as zero and are ignored on write, with no effect on the collector either. These include a page at or beyond the page count, buffer offsets outside page 0, a 64-bit access not 8-byte aligned, and a 64-bit access to a bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wide_i | input | 1 | Access size: 1 = 64-bit, 0 = 32-bit |
| addr_i | input | ADDR_W (16) | Byte address |
| wdata_i | input | 64 | Write data; 32-bit accesses use bits 31:0 |
| rdata_o | output | 64 | Read data, one cycle after the strobe |
| wide_regs_o | output | NUM_PAGES*NUM_WIDE*128 | Wide registers, flat index p*NUM_WIDE+i |
| byp_regs_o | output | NUM_PAGES*NUM_BYP*32 | Bypass registers, flat index p*NUM_BYP+j |
| buf_tbl_o | output | NUM_BUF*64 | Buffer table entries |

## Verification
The checker watches several properties on every cycle. No wide register moves except on a top-piece write, and a bypass write never alters the collector. The shadow holds between offset-0 reads, read data falls to zero after idle and unmapped reads, and ignored writes leave every output vector still. Other behaviours depend on history across accesses, so only the bench's scenarios can show them. These are the assembled value built from stale collector pieces, shadow data outliving a rewrite of the live register, interleaved bypass writes, buffer hold-then-commit, and page separation. The bench checks them against a behavioural model compared on each clock.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  localparam int unsigned IDX_W      = 8;
  localparam int unsigned WREG_W     = 128;
  localparam int unsigned DW_W       = 32;
  localparam int unsigned QW_W       = 64;
  localparam int unsigned REG_STRIDE = 16;
  localparam int unsigned BUF_STRIDE = 8;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_WIDE = 2'd1,
    RGN_BYP  = 2'd2,
    RGN_BUF  = 2'd3
  } rgn_e;

  typedef struct packed {
    rgn_e             rgn;
    logic [IDX_W-1:0] idx;
    logic [1:0]       dw;
  } dec_t;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
  import wrc_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 2,
  parameter int unsigned NUM_WIDE   = 4,
  parameter int unsigned NUM_BYP    = 3,
  parameter int unsigned NUM_BUF    = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned BYP_BASE   = 'h100,
  parameter int unsigned BUF_BASE   = 'h1000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output dec_t              dec_o
);
  localparam int unsigned PAGE_SIZE = 1 << PAGE_SHIFT;
  localparam int unsigned WIDE_SPAN = NUM_WIDE * REG_STRIDE;
  localparam int unsigned BYP_SPAN  = NUM_BYP * REG_STRIDE;
  localparam int unsigned BUF_SPAN  = NUM_BUF * BUF_STRIDE;

  always_comb begin
    int unsigned pg;
    int unsigned of;
    logic        aligned;
    pg      = 32'(addr_i) >> PAGE_SHIFT;
    of      = 32'(addr_i) & (PAGE_SIZE - 1);
    aligned = (addr_i[1:0] == 2'b00) && !(wide_i && addr_i[2]);
    dec_o   = '{rgn: RGN_NONE, idx: '0, dw: '0};
    if (aligned && pg < NUM_PAGES) begin
      if (of < WIDE_SPAN) begin
        dec_o.rgn = RGN_WIDE;
        dec_o.idx = IDX_W'(pg * NUM_WIDE + of / REG_STRIDE);
        dec_o.dw  = addr_i[3:2];
      end else if (!wide_i && of >= BYP_BASE && of < BYP_BASE + BYP_SPAN
                   && (of % REG_STRIDE) == 0) begin
        dec_o.rgn = RGN_BYP;
        dec_o.idx = IDX_W'(pg * NUM_BYP + (of - BYP_BASE) / REG_STRIDE);
      end else if (pg == 0 && of >= BUF_BASE && of < BUF_BASE + BUF_SPAN) begin
        dec_o.rgn = RGN_BUF;
        dec_o.idx = IDX_W'((of - BUF_BASE) / BUF_STRIDE);
        dec_o.dw  = {1'b0, addr_i[2]};
      end
    end
  end
endmodule

// File: rtl/wrc_collector.sv
module wrc_collector
  import wrc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [1:0]        dw_i,
  input  logic [QW_W-1:0]   wdata_i,
  output logic              commit_o,
  output logic [WREG_W-1:0] commit_data_o,
  output logic [WREG_W-1:0] coll_o
);
  logic [DW_W-1:0] piece_q [4];

  // top piece: dword 3 for 32-bit, qword 1 for 64-bit
  assign commit_o = wr_i && (wide_i ? (dw_i == 2'd2) : (dw_i == 2'd3));

  always_comb begin
    if (wide_i) commit_data_o = {wdata_i, piece_q[1], piece_q[0]};
    else        commit_data_o = {wdata_i[DW_W-1:0], piece_q[2], piece_q[1], piece_q[0]};
  end

  assign coll_o = {piece_q[3], piece_q[2], piece_q[1], piece_q[0]};

  generate
    for (genvar k = 0; k < 4; k++) begin : g_piece
      logic ld32, ld64;
      assign ld32 = wr_i && !wide_i && (dw_i == 2'(k)) && (k != 3);
      assign ld64 = wr_i &&  wide_i && (dw_i == 2'd0) && (k < 2);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   piece_q[k] <= '0;
        else if (ld32) piece_q[k] <= wdata_i[DW_W-1:0];
        else if (ld64) piece_q[k] <= wdata_i[(k%2)*DW_W +: DW_W];
      end
    end
  endgenerate
endmodule

// File: rtl/wrc_buf_table.sv
module wrc_buf_table
  import wrc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic                    wide_i,
  input  logic [1:0]              dw_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [QW_W-1:0]         wdata_i,
  output logic [NUM_BUF*QW_W-1:0] entries_o
);
  logic [DW_W-1:0] hold_q;
  logic            commit;
  logic [QW_W-1:0] commit_data;

  assign commit      = wr_i && (wide_i ? (dw_i == 2'd0) : (dw_i == 2'd1));
  assign commit_data = wide_i ? wdata_i : {wdata_i[DW_W-1:0], hold_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             hold_q <= '0;
    else if (wr_i && !wide_i && dw_i == 2'd0) hold_q <= wdata_i[DW_W-1:0];
  end

  generate
    for (genvar e = 0; e < NUM_BUF; e++) begin : g_ent
      logic [QW_W-1:0] ent_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              ent_q <= '0;
        else if (commit && idx_i == IDX_W'(e)) ent_q <= commit_data;
      end
      assign entries_o[e*QW_W +: QW_W] = ent_q;
    end
  endgenerate
endmodule

// File: rtl/wrc_rdpath.sv
module wrc_rdpath
  import wrc_pkg::*;
#(
  parameter int unsigned N_WIDE = 8,
  parameter int unsigned N_BYP  = 6,
  parameter int unsigned N_BUF  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_i,
  input  logic                     wide_i,
  input  dec_t                     dec_i,
  input  logic [N_WIDE*WREG_W-1:0] wide_regs_i,
  input  logic [N_BYP*DW_W-1:0]    byp_regs_i,
  input  logic [N_BUF*QW_W-1:0]    buf_i,
  output logic [QW_W-1:0]          rdata_o,
  output logic [WREG_W-1:0]        shadow_o
);
  int unsigned       widx, bidx, eidx;
  logic [WREG_W-1:0] live;
  logic [DW_W-1:0]   byp_val;
  logic [QW_W-1:0]   ent_val;
  logic [QW_W-1:0]   rd_next;
  logic              snap;

  always_comb begin
    widx    = (int'(dec_i.idx) < N_WIDE) ? int'(dec_i.idx) : 0;
    bidx    = (int'(dec_i.idx) < N_BYP)  ? int'(dec_i.idx) : 0;
    eidx    = (int'(dec_i.idx) < N_BUF)  ? int'(dec_i.idx) : 0;
    live    = wide_regs_i[widx*WREG_W +: WREG_W];
    byp_val = byp_regs_i[bidx*DW_W +: DW_W];
    ent_val = buf_i[eidx*QW_W +: QW_W];
  end

  assign snap = rd_i && dec_i.rgn == RGN_WIDE && dec_i.dw == 2'd0;

  always_comb begin
    rd_next = '0;
    if (rd_i) begin
      unique case (dec_i.rgn)
        RGN_WIDE: begin
          if (dec_i.dw == 2'd0)
            rd_next = wide_i ? live[QW_W-1:0] : {32'h0, live[DW_W-1:0]};
          else if (wide_i)
            rd_next = shadow_o[WREG_W-1:QW_W];
          else
            rd_next = {32'h0, shadow_o[dec_i.dw*DW_W +: DW_W]};
        end
        RGN_BYP:  rd_next = {32'h0, byp_val};
        RGN_BUF: begin
          if (wide_i)               rd_next = ent_val;
          else if (dec_i.dw[0])     rd_next = {32'h0, ent_val[QW_W-1:DW_W]};
          else                      rd_next = {32'h0, ent_val[DW_W-1:0]};
        end
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      shadow_o <= '0;
    end else begin
      rdata_o <= rd_next;
      if (snap) shadow_o <= live;
    end
  end
endmodule

// File: rtl/wreg_collector.sv
module wreg_collector
  import wrc_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 2,
  parameter int unsigned NUM_WIDE   = 4,
  parameter int unsigned NUM_BYP    = 3,
  parameter int unsigned NUM_BUF    = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned BYP_BASE   = 'h100,
  parameter int unsigned BUF_BASE   = 'h1000
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic                                re_i,
  input  logic                                wide_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [63:0]                         wdata_i,
  output logic [63:0]                         rdata_o,
  output logic [NUM_PAGES*NUM_WIDE*128-1:0]   wide_regs_o,
  output logic [NUM_PAGES*NUM_BYP*32-1:0]     byp_regs_o,
  output logic [NUM_BUF*64-1:0]               buf_tbl_o
);
  localparam int unsigned N_WIDE = NUM_PAGES * NUM_WIDE;
  localparam int unsigned N_BYP  = NUM_PAGES * NUM_BYP;

  dec_t              dec;
  logic              wr_wide, wr_byp, wr_buf;
  logic              commit;
  logic [WREG_W-1:0] commit_data;
  logic [WREG_W-1:0] coll_q;
  logic [WREG_W-1:0] shadow_q;

  wrc_decode #(
    .NUM_PAGES (NUM_PAGES),
    .NUM_WIDE  (NUM_WIDE),
    .NUM_BYP   (NUM_BYP),
    .NUM_BUF   (NUM_BUF),
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .BYP_BASE  (BYP_BASE),
    .BUF_BASE  (BUF_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .wide_i(wide_i),
    .dec_o (dec)
  );

  assign wr_wide = we_i && dec.rgn == RGN_WIDE;
  assign wr_byp  = we_i && dec.rgn == RGN_BYP;
  assign wr_buf  = we_i && dec.rgn == RGN_BUF;

  wrc_collector u_coll (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_wide),
    .wide_i       (wide_i),
    .dw_i         (dec.dw),
    .wdata_i      (wdata_i),
    .commit_o     (commit),
    .commit_data_o(commit_data),
    .coll_o       (coll_q)
  );

  generate
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
      logic [WREG_W-1:0] reg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              reg_q <= '0;
        else if (commit && dec.idx == IDX_W'(g)) reg_q <= commit_data;
      end
      assign wide_regs_o[g*WREG_W +: WREG_W] = reg_q;
    end

    for (genvar g = 0; g < N_BYP; g++) begin : g_byp
      logic [DW_W-1:0] reg_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              reg_q <= '0;
        else if (wr_byp && dec.idx == IDX_W'(g)) reg_q <= wdata_i[DW_W-1:0];
      end
      assign byp_regs_o[g*DW_W +: DW_W] = reg_q;
    end
  endgenerate

  wrc_buf_table #(
    .NUM_BUF(NUM_BUF)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_buf),
    .wide_i   (wide_i),
    .dw_i     (dec.dw),
    .idx_i    (dec.idx),
    .wdata_i  (wdata_i),
    .entries_o(buf_tbl_o)
  );

  wrc_rdpath #(
    .N_WIDE(N_WIDE),
    .N_BYP (N_BYP),
    .N_BUF (NUM_BUF)
  ) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (re_i),
    .wide_i     (wide_i),
    .dec_i      (dec),
    .wide_regs_i(wide_regs_o),
    .byp_regs_i (byp_regs_o),
    .buf_i      (buf_tbl_o),
    .rdata_o    (rdata_o),
    .shadow_o   (shadow_q)
  );
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker
  import wrc_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 2,
  parameter int unsigned NUM_WIDE  = 4,
  parameter int unsigned NUM_BYP   = 3,
  parameter int unsigned NUM_BUF   = 8
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              we_i,
  input logic                              re_i,
  input logic                              wide_i,
  input logic [3:0]                        addr_lo_i,
  input logic [63:0]                       rdata_i,
  input logic [NUM_PAGES*NUM_WIDE*128-1:0] wide_regs_i,
  input logic [NUM_PAGES*NUM_BYP*32-1:0]   byp_regs_i,
  input logic [NUM_BUF*64-1:0]             buf_i,
  input logic [127:0]                      coll_i,
  input logic [127:0]                      shadow_i,
  input logic [1:0]                        rgn_i
);
  logic top_piece;
  assign top_piece = wide_i ? (addr_lo_i == 4'h8) : (addr_lo_i == 4'hC);

  AST_WIDE_ONLY_ON_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && top_piece) |=> $stable(wide_regs_i)); // R2

  AST_BYP_KEEPS_COLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rgn_i == RGN_BYP) |=> $stable(coll_i)); // R8

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_i && addr_lo_i == 4'h0) |=> $stable(shadow_i)); // R5

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_i == 64'h0)); // R6

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(byp_regs_i) && $stable(buf_i))); // R7

  AST_BUF_LOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wide_i && rgn_i == RGN_BUF && addr_lo_i[2] == 1'b0) |=> $stable(buf_i)); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rgn_i == RGN_NONE) |=> (rdata_i == 64'h0)); // R11

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && rgn_i == RGN_NONE) |=> ($stable(wide_regs_i) && $stable(byp_regs_i)
                                     && $stable(buf_i) && $stable(coll_i))); // R11
endmodule

bind wreg_collector wrc_checker #(
  .NUM_PAGES(NUM_PAGES),
  .NUM_WIDE (NUM_WIDE),
  .NUM_BYP  (NUM_BYP),
  .NUM_BUF  (NUM_BUF)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .re_i       (re_i),
  .wide_i     (wide_i),
  .addr_lo_i  (addr_i[3:0]),
  .rdata_i    (rdata_o),
  .wide_regs_i(wide_regs_o),
  .byp_regs_i (byp_regs_o),
  .buf_i      (buf_tbl_o),
  .coll_i     (coll_q),
  .shadow_i   (shadow_q),
  .rgn_i      (dec.rgn)
);

// File: tb/wreg_collector_bench.sv
`timescale 1ns/1ps
module wreg_collector_bench;
  localparam int NP = 2, NW = 4, NB = 3, NBUF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, wide = 1'b0;
  logic [15:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [NP*NW*128-1:0] wregs;
  logic [NP*NB*32-1:0]  bregs;
  logic [NBUF*64-1:0]   btbl;

  always #2 clk = ~clk;

  wreg_collector u_wreg_collector (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wide_regs_o(wregs), .byp_regs_o(bregs), .buf_tbl_o(btbl)
  );

  // behavioural reference
  logic [127:0] m_wide [NP*NW];
  logic [31:0]  m_byp  [NP*NB];
  logic [63:0]  m_buf  [NBUF];
  logic [31:0]  m_coll [4];
  logic [31:0]  m_hold;
  logic [127:0] m_shadow;
  logic [63:0]  m_rd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(string req, string what, logic [1023:0] act, logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NP*NW; i++) m_wide[i] = '0;
    for (int i = 0; i < NP*NB; i++) m_byp[i] = '0;
    for (int i = 0; i < NBUF; i++) m_buf[i] = '0;
    for (int i = 0; i < 4; i++) m_coll[i] = '0;
    m_hold = '0; m_shadow = '0; m_rd = '0;
  endtask

  task automatic model_step();
    int unsigned a, pg, of, kind, s, k;
    a = addr; pg = a >> 13; of = a & 32'h1FFF; kind = 0; s = 0;
    if (a % 4 == 0 && !(wide && a % 8 != 0) && pg < NP) begin
      if (of < NW*16) begin kind = 1; s = pg*NW + of/16; end
      else if (!wide && of >= 'h100 && of < 'h100 + NB*16 && of % 16 == 0) begin
        kind = 2; s = pg*NB + (of - 'h100)/16;
      end else if (pg == 0 && of >= 'h1000 && of < 'h1000 + NBUF*8) begin
        kind = 3; s = (of - 'h1000)/8;
      end
    end
    m_rd = '0;
    if (re) begin
      if (kind == 1) begin
        k = (of % 16)/4;
        if (k == 0) begin
          m_rd = wide ? m_wide[s][63:0] : {32'h0, m_wide[s][31:0]};
          m_shadow = m_wide[s];
        end else m_rd = wide ? m_shadow[127:64] : {32'h0, m_shadow[k*32 +: 32]};
      end else if (kind == 2) m_rd = {32'h0, m_byp[s]};
      else if (kind == 3) begin
        if (wide) m_rd = m_buf[s];
        else if (of % 8 == 4) m_rd = {32'h0, m_buf[s][63:32]};
        else m_rd = {32'h0, m_buf[s][31:0]};
      end
    end
    if (we) begin
      if (kind == 1) begin
        k = (of % 16)/4;
        if (!wide) begin
          if (k < 3) m_coll[k] = wdata[31:0];
          else m_wide[s] = {wdata[31:0], m_coll[2], m_coll[1], m_coll[0]};
        end else if (k == 0) begin
          m_coll[0] = wdata[31:0]; m_coll[1] = wdata[63:32];
        end else m_wide[s] = {wdata, m_coll[1], m_coll[0]};
      end else if (kind == 2) m_byp[s] = wdata[31:0];
      else if (kind == 3) begin
        if (wide) m_buf[s] = wdata;
        else if (of % 8 == 0) m_hold = wdata[31:0];
        else m_buf[s] = {wdata[31:0], m_hold};
      end
    end
  endtask

  task automatic compare_all();
    logic [1023:0] ew, eb, et;
    ew = '0; eb = '0; et = '0;
    for (int i = 0; i < NP*NW; i++) ew[i*128 +: 128] = m_wide[i];
    for (int i = 0; i < NP*NB; i++) eb[i*32 +: 32] = m_byp[i];
    for (int i = 0; i < NBUF; i++) et[i*64 +: 64] = m_buf[i];
    check(cur_req, "rdata", 1024'(rdata), 1024'(m_rd));
    check(cur_req, "wide_regs", 1024'(wregs), ew);
    check(cur_req, "byp_regs", 1024'(bregs), eb);
    check(cur_req, "buf_tbl", 1024'(btbl), et);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic acc(bit w, bit r, bit wd, int unsigned a, logic [63:0] d);
    we = w; re = r; wide = wd; addr = a[15:0]; wdata = d;
    cyc();
    we = 0; re = 0; wide = 0; addr = '0; wdata = '0;
  endtask

  task automatic wr32(int unsigned a, logic [31:0] d); acc(1, 0, 0, a, {32'h0, d}); endtask
  task automatic wr64(int unsigned a, logic [63:0] d); acc(1, 0, 1, a, d); endtask
  task automatic rd32(int unsigned a); acc(0, 1, 0, a, '0); endtask
  task automatic rd64(int unsigned a); acc(0, 1, 1, a, '0); endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset rdata", 1024'(rdata), '0);
    check("R1", "reset wide", 1024'(wregs), '0);
    check("R1", "reset byp", 1024'(bregs), '0);
    check("R1", "reset buf", 1024'(btbl), '0);
    rst_n = 1'b1;
    cyc();

    // R2: four 32-bit pieces to reg1 page0, idle gap in between
    cur_req = "R2";
    wr32('h10, 32'hA0A0_0001);
    wr32('h14, 32'hB0B0_0002);
    wr32('h18, 32'hC0C0_0003);
    cyc();
    check("R2", "reg1 before top", 1024'(wregs[1*128 +: 128]), '0);
    wr32('h1C, 32'hD0D0_0004);
    check("R2", "reg1 commit", 1024'(wregs[1*128 +: 128]),
          1024'({32'hD0D0_0004, 32'hC0C0_0003, 32'hB0B0_0002, 32'hA0A0_0001}));

    // R3: 64-bit pair to reg2
    cur_req = "R3";
    wr64('h20, 64'h1111_2222_3333_4444);
    wr64('h28, 64'h5555_6666_7777_8888);
    check("R3", "reg2 commit", 1024'(wregs[2*128 +: 128]),
          1024'({64'h5555_6666_7777_8888, 64'h1111_2222_3333_4444}));

    // R4: lone top piece reuses stale collector contents
    cur_req = "R4";
    wr32('h3C, 32'hEEEE_0005);
    check("R4", "reg3 stale pieces", 1024'(wregs[3*128 +: 128]),
          1024'({32'hEEEE_0005, 32'hC0C0_0003, 64'h1111_2222_3333_4444}));

    // R5: snapshot then live rewrite; shadow still returns old data
    cur_req = "R5";
    rd32('h10);
    rd32('h14);
    wr32('h10, 32'h0F0F_0F0F); wr32('h14, 32'h1F1F_1F1F);
    wr32('h18, 32'h2F2F_2F2F); wr32('h1C, 32'h3F3F_3F3F);
    rd32('h18);
    check("R5", "shadow after rewrite", 1024'(rdata), 1024'(64'hC0C0_0003));
    rd32('h1C);
    rd64('h20);
    rd64('h28);
    check("R5", "64-bit shadow high", 1024'(rdata), 1024'(64'h5555_6666_7777_8888));
    rd32('h00);
    rd32('h3C);

    // R6: latency and idle zero
    cur_req = "R6";
    rd32('h10);
    check("R6", "32-bit zero extend", 1024'(rdata), 1024'(64'h0F0F_0F0F));
    cyc();
    check("R6", "idle rdata", 1024'(rdata), '0);

    // R7: bypass registers
    cur_req = "R7";
    wr32('h100, 32'h0000_0AAA);
    wr32('h110, 32'h0000_0BBB);
    wr32('h120, 32'h0000_0CCC);
    rd32('h110);
    check("R7", "bypass read", 1024'(rdata), 1024'(64'h0BBB));

    // R8: bypass writes interleaved with partial wide writes
    cur_req = "R8";
    wr32('h00, 32'h0000_00D0);
    wr32('h04, 32'h0000_00D1);
    wr32('h120, 32'h1234_5678);
    wr32('h08, 32'h0000_00D2);
    wr32('h100, 32'h8765_4321);
    wr32('h0C, 32'h0000_00D3);
    check("R8", "reg0 after bypass", 1024'(wregs[127:0]),
          1024'({32'hD3, 32'hD2, 32'hD1, 32'hD0}));
    wr64('h30, 64'hCAFE_0000_BEEF_0000);
    wr32('h2110, 32'h0000_7777);
    wr64('h38, 64'h0123_4567_89AB_CDEF);

    // R9: buffer table
    cur_req = "R9";
    wr32('h1010, 32'h9999_0001);
    check("R9", "entry2 held", 1024'(btbl[2*64 +: 64]), '0);
    wr32('h1014, 32'h9999_0002);
    check("R9", "entry2 commit", 1024'(btbl[2*64 +: 64]), 1024'(64'h9999_0002_9999_0001));
    wr64('h1038, 64'hFEDC_BA98_7654_3210);
    rd32('h103C);
    rd32('h1038);
    rd64('h1010);

    // R10: page 1 copies
    cur_req = "R10";
    wr32('h2010, 32'h5A5A_0000); wr32('h2014, 32'h5A5A_0001);
    wr32('h2018, 32'h5A5A_0002); wr32('h201C, 32'h5A5A_0003);
    check("R10", "page0 reg1 kept", 1024'(wregs[1*128 +: 128]),
          1024'({32'h3F3F_3F3F, 32'h2F2F_2F2F, 32'h1F1F_1F1F, 32'h0F0F_0F0F}));
    wr32('h2100, 32'h0000_4242);
    rd32('h2010);
    rd32('h2018);
    rd32('h2100);
    rd64('h2030);

    // R11: unmapped
    cur_req = "R11";
    wr32('h4010, 32'hDEAD_0001);
    wr32('h3010, 32'hDEAD_0002);
    wr64('h14, 64'hDEAD_DEAD_DEAD_0003);
    wr64('h100, 64'hDEAD_0004);
    wr32('h104, 32'hDEAD_0005);
    wr32('h0C, 32'h0000_00E3);
    rd64('h100);
    check("R11", "64-bit bypass read", 1024'(rdata), '0);
    rd32('h4000);
    rd32('h1800);
    rd64('h04);

    // mixed traffic across all regions
    cur_req = "R10";
    for (int i = 0; i < 600; i++) begin
      int unsigned sel, a, p;
      sel = $urandom % 8;
      p = ($urandom % 3) * 'h2000;
      case (sel)
        0, 1: a = p + ($urandom % NW)*16 + ($urandom % 4)*4;
        2:    a = p + 'h100 + ($urandom % NB)*16;
        3:    a = 'h1000 + ($urandom % NBUF)*8 + ($urandom % 2)*4;
        4:    a = p + ($urandom % NW)*16 + ($urandom % 2)*8;
        default: a = $urandom % 'h5000;
      endcase
      acc($urandom % 2, ($urandom % 3) == 0, $urandom % 2, a,
          {$urandom, $urandom});
    end

    repeat (2) cyc();
    finish_run();
  end
endmodule